// File: doc/BRIEF.md
# Debug Scan-Chain Command Decoder

This block sits on the test clock behind a boundary-scan TAP whose debug instruction is active. It watches the TAP's capture, shift and update data-register indications and collects the serial data stream from the test data input. The stream length varies from command to command. When the update indication arrives, the decoder reads the collected stream. The stream either picks one of three sub-units (the system bus port, CPU 0 or CPU 1), or it carries a command to the sub-unit that is currently picked.

Sub-unit commands take three forms. The first picks an internal register. The second writes an internal register. The third starts a burst, and for it the decoder passes the operation, address and word count to a separate transfer engine. Every sub-unit keeps its own small internal registers. The bus sub-unit keeps a sticky error record, and each CPU sub-unit keeps a stall bit and a reset bit. A NOP scan reads out the register that is currently picked: its contents leave on the test data output, least significant bit first, while the scan shifts.

Top module: `dbgcmd_top`

## Requirements
- R1: Stream bits are shifted in least-significant first. The last bit shifted (stream MSB) is a flag: 1 means sub-unit pick and 0 means sub-unit command. The 4-bit opcode sits directly below the flag, so the decode does not depend on the stream length.
- R2: A pick is the 3-bit stream {1, id[1:0]}, where id 0 is bus, 1 is CPU 0 and 2 is CPU 1. `unit_o` shows the new id from the update clock edge on.
- R3: A pick that names id 3 leaves `unit_o` unchanged.
- R4: Register select has opcode 4'hD. Its stream is {0, 4'hD, idx}, 6 bits long, and it sets the selected sub-unit's register index to idx.
- R5: Register write has opcode 4'h9 and places the data in the low bits. For the bus sub-unit the stream is {0, 4'h9, idx, d} (7 bits). For a CPU sub-unit it is {0, 4'h9, idx, d[1:0]} (8 bits); when idx is 0, d[0] sets the stall bit and d[1] sets the reset bit. A write also selects idx.
- R6: At capture the selected register of the current sub-unit is loaded and then shifted out on `tdo_o`, LSB first, one bit per shift cycle. A CPU sub-unit's index 0 reads {reset, stall}, and index 1 reads zero. An all-zero 5-bit stream is a NOP and changes no state.
- R7: Bus index 0 is a 33-bit error record. Bit 0 is the flag and bits 32:1 are the failing address. An `err_report_i` pulse fills the record only while the flag is clear, so the first error is kept. Writing d=1 to index 0 clears the record, and writing d=0 leaves it unchanged.
- R8: A burst is the 53-bit stream {0, op[3:0], addr[31:0], len[15:0]}, where op is 1, 2 or 3 for writes and 5, 6 or 7 for reads. It pulses `burst_go_o` for one cycle after the update edge, with the op, addr, len and current unit held on the burst outputs.
- R9: While `burst_busy_i` is high, an update is ignored: no pick, no register change, no burst start.
- R10: `tlr_i` (test-logic reset) returns the unit to bus, clears the stream register and zeroes all stall and reset bits.
- R11: While `dbg_sel_i` is low the decoder neither shifts nor decodes.
- R12: A register write changes only the sub-unit selected at the time of the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| tlr_i | input | 1 | Test-logic reset, active high, asynchronous |
| dbg_sel_i | input | 1 | Debug instruction is active in the TAP |
| capture_dr_i | input | 1 | TAP in capture data-register state |
| shift_dr_i | input | 1 | TAP in shift data-register state |
| update_dr_i | input | 1 | TAP in update data-register state |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| burst_busy_i | input | 1 | Transfer engine is running a burst |
| err_report_i | input | 1 | Bus error pulse from the engine |
| err_addr_i | input | 32 | Address of the failing bus access |
| unit_o | output | 2 | Currently picked sub-unit |
| cpu_stall_o | output | 2 | Stall bit per CPU sub-unit |
| cpu_reset_o | output | 2 | Reset bit per CPU sub-unit |
| burst_go_o | output | 1 | One-cycle burst start |
| burst_op_o | output | 4 | Burst opcode |
| burst_addr_o | output | 32 | Burst start address |
| burst_len_o | output | 16 | Burst word count |
| burst_unit_o | output | 2 | Sub-unit that owns the burst |

## Verification
The bench drives picks and writes with streams of different lengths. A decoder that reads the fields from fixed low positions instead of from the flag end would land data in the wrong CPU bits or in the wrong sub-unit. It scans the illegal id 3, a busy update and a scan with the debug instruction inactive; a design that fails to ignore any of these changes `unit_o` or fires `burst_go_o`. It reports two bus errors in a row and reads the record back serially. A design that overwrites the first error, clears the record on a zero write or shifts MSB first shows a different 33-bit value. A reset in the middle of the run must leave the unit on bus and every stall and reset bit at zero.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;
    localparam int OP_W    = 4;
    localparam int ID_W    = 2;
    localparam int CPU_N   = 2;
    localparam logic [OP_W-1:0] OP_REG_WR  = 4'h9;
    localparam logic [OP_W-1:0] OP_REG_SEL = 4'hD;
    localparam logic [ID_W-1:0] UNIT_BUS   = 2'd0;

    function automatic logic is_burst(input logic [OP_W-1:0] op);
        return (op[3] == 1'b0) && (op[1:0] != 2'b00);
    endfunction
endpackage

// File: rtl/dbgcmd_shifter.sv
module dbgcmd_shifter #(
    parameter int W = 53
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         capture_i,
    input  logic         shift_i,
    input  logic         tdi_i,
    output logic [W-1:0] sr_o
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (en_i && capture_i)
            sr_d = '0;
        else if (en_i && shift_i)
            sr_d = {tdi_i, sr_q[W-1:1]};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) sr_q <= '0;
        else       sr_q <= sr_d;
    end

    assign sr_o = sr_q;

    // newest bit always enters at the flag end
    assert_lsb_first_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && shift_i && !capture_i) |=> (sr_q[W-1] == $past(tdi_i)));
endmodule

// File: rtl/dbgcmd_bus_regs.sv
module dbgcmd_bus_regs #(
    parameter int AW = 32
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        sel_we_i,
    input  logic        wr_we_i,
    input  logic        idx_i,
    input  logic        wr_bit_i,
    input  logic        err_report_i,
    input  logic [AW-1:0] err_addr_i,
    output logic [AW:0] rd_o
);
    typedef struct packed {
        logic        idx;
        logic [AW:0] err;
    } bus_st_t;

    bus_st_t d, q;
    logic    clr;

    always_comb begin
        d   = q;
        clr = wr_we_i && !idx_i && wr_bit_i;
        if (sel_we_i || wr_we_i) d.idx = idx_i;
        if (clr)
            d.err = '0;
        else if (err_report_i && !q.err[0])
            d.err = {err_addr_i, 1'b1};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign rd_o = q.idx ? '0 : q.err;

    // a recorded error is frozen until an explicit clear
    assert_first_err_kept_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.err[0] && !(wr_we_i && !idx_i && wr_bit_i)) |=> $stable(q.err));
endmodule

// File: rtl/dbgcmd_cpu_regs.sv
module dbgcmd_cpu_regs (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       sel_we_i,
    input  logic       wr_we_i,
    input  logic       idx_i,
    input  logic [1:0] wr_bits_i,
    output logic       stall_o,
    output logic       reset_o,
    output logic [1:0] rd_o
);
    typedef struct packed {
        logic idx;
        logic rst;
        logic stall;
    } cpu_st_t;

    cpu_st_t d, q;

    always_comb begin
        d = q;
        if (sel_we_i || wr_we_i) d.idx = idx_i;
        if (wr_we_i && !idx_i) begin
            d.stall = wr_bits_i[0];
            d.rst   = wr_bits_i[1];
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign stall_o = q.stall;
    assign reset_o = q.rst;
    assign rd_o    = q.idx ? 2'b00 : {q.rst, q.stall};

    // control bits move only on a write aimed at this sub-unit
    assert_hold_unless_written_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_we_i |=> $stable({q.rst, q.stall}));
endmodule

// File: rtl/dbgcmd_top.sv
module dbgcmd_top
    import dbgcmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              tck_i,
    input  logic              tlr_i,
    input  logic              dbg_sel_i,
    input  logic              capture_dr_i,
    input  logic              shift_dr_i,
    input  logic              update_dr_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    input  logic              burst_busy_i,
    input  logic              err_report_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    output logic [ID_W-1:0]   unit_o,
    output logic [CPU_N-1:0]  cpu_stall_o,
    output logic [CPU_N-1:0]  cpu_reset_o,
    output logic              burst_go_o,
    output logic [OP_W-1:0]   burst_op_o,
    output logic [ADDR_W-1:0] burst_addr_o,
    output logic [LEN_W-1:0]  burst_len_o,
    output logic [ID_W-1:0]   burst_unit_o
);
    localparam int SR_W   = 1 + OP_W + ADDR_W + LEN_W;
    localparam int RD_W   = ADDR_W + 1;
    localparam int IDX_AT = SR_W - 2 - OP_W;

    typedef struct packed {
        logic [ID_W-1:0]   unit;
        logic [RD_W-1:0]   out;
        logic              go;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [ID_W-1:0]   bunit;
    } top_st_t;

    top_st_t d, q;

    logic [SR_W-1:0]  sr;
    logic [RD_W-1:0]  bus_rd;
    logic [1:0]       cpu_rd [CPU_N];
    logic             upd, cmd, flag, idx;
    logic [ID_W-1:0]  id;
    logic [OP_W-1:0]  op;
    logic             do_sel, do_wr;
    logic [RD_W-1:0]  rd_mux;

    dbgcmd_shifter #(.W(SR_W)) u_shift (
        .clk_i(tck_i), .rst_i(tlr_i), .en_i(dbg_sel_i),
        .capture_i(capture_dr_i), .shift_i(shift_dr_i),
        .tdi_i(tdi_i), .sr_o(sr)
    );

    always_comb begin
        upd    = update_dr_i && dbg_sel_i && !burst_busy_i;
        flag   = sr[SR_W-1];
        id     = sr[SR_W-2 -: ID_W];
        op     = sr[SR_W-2 -: OP_W];
        idx    = sr[IDX_AT];
        cmd    = upd && !flag;
        do_sel = cmd && (op == OP_REG_SEL);
        do_wr  = cmd && (op == OP_REG_WR);
    end

    dbgcmd_bus_regs #(.AW(ADDR_W)) u_bus (
        .clk_i(tck_i), .rst_i(tlr_i),
        .sel_we_i(do_sel && (q.unit == UNIT_BUS)),
        .wr_we_i(do_wr && (q.unit == UNIT_BUS)),
        .idx_i(idx), .wr_bit_i(sr[IDX_AT-1]),
        .err_report_i(err_report_i), .err_addr_i(err_addr_i),
        .rd_o(bus_rd)
    );

    for (genvar k = 0; k < CPU_N; k++) begin : g_cpu
        dbgcmd_cpu_regs u_cpu (
            .clk_i(tck_i), .rst_i(tlr_i),
            .sel_we_i(do_sel && (q.unit == ID_W'(k + 1))),
            .wr_we_i(do_wr && (q.unit == ID_W'(k + 1))),
            .idx_i(idx), .wr_bits_i(sr[IDX_AT-1 -: 2]),
            .stall_o(cpu_stall_o[k]), .reset_o(cpu_reset_o[k]),
            .rd_o(cpu_rd[k])
        );
    end

    always_comb begin
        rd_mux = bus_rd;
        for (int k = 0; k < CPU_N; k++)
            if (q.unit == ID_W'(k + 1)) rd_mux = RD_W'(cpu_rd[k]);
    end

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (upd && flag && (int'(id) <= CPU_N))
            d.unit = id;
        if (cmd && is_burst(op)) begin
            d.go    = 1'b1;
            d.op    = op;
            d.addr  = sr[IDX_AT -: ADDR_W];
            d.len   = sr[LEN_W-1:0];
            d.bunit = q.unit;
        end
        if (dbg_sel_i && capture_dr_i)
            d.out = rd_mux;
        else if (dbg_sel_i && shift_dr_i)
            d.out = {1'b0, q.out[RD_W-1:1]};
    end

    always_ff @(posedge tck_i or posedge tlr_i) begin
        if (tlr_i) q <= '0;
        else       q <= d;
    end

    assign tdo_o        = q.out[0];
    assign unit_o       = q.unit;
    assign burst_go_o   = q.go;
    assign burst_op_o   = q.op;
    assign burst_addr_o = q.addr;
    assign burst_len_o  = q.len;
    assign burst_unit_o = q.bunit;

    assert_bad_id_keeps_unit_R3: assert property (@(posedge tck_i) disable iff (tlr_i)
        (update_dr_i && dbg_sel_i && flag && (int'(id) > CPU_N)) |=> $stable(unit_o));

    assert_go_after_update_R8: assert property (@(posedge tck_i) disable iff (tlr_i)
        burst_go_o |-> $past(update_dr_i && dbg_sel_i));

    assert_busy_freezes_R9: assert property (@(posedge tck_i) disable iff (tlr_i)
        burst_busy_i |=> ($stable(unit_o) && !burst_go_o));

    assert_idle_when_unselected_R11: assert property (@(posedge tck_i) disable iff (tlr_i)
        !dbg_sel_i |=> ($stable(unit_o) && !burst_go_o));
endmodule

// File: tb/dbgcmd_top_test.sv
module dbgcmd_top_test;
    logic        clk = 1'b0;
    logic        tlr = 1'b1;
    logic        dsel = 1'b1, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic        busy = 1'b0, erep = 1'b0;
    logic [31:0] eaddr = '0;
    logic        tdo, go;
    logic [1:0]  unit, stall, rstb, bunit;
    logic [3:0]  bop;
    logic [31:0] baddr;
    logic [15:0] blen;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    dbgcmd_top uut (
        .tck_i(clk), .tlr_i(tlr), .dbg_sel_i(dsel), .capture_dr_i(cap),
        .shift_dr_i(sh), .update_dr_i(upd), .tdi_i(tdi), .tdo_o(tdo),
        .burst_busy_i(busy), .err_report_i(erep), .err_addr_i(eaddr),
        .unit_o(unit), .cpu_stall_o(stall), .cpu_reset_o(rstb),
        .burst_go_o(go), .burst_op_o(bop), .burst_addr_o(baddr),
        .burst_len_o(blen), .burst_unit_o(bunit)
    );

    typedef struct packed {
        logic [63:0] v;
        logic [7:0]  n;
        logic [1:0]  u;
        logic [1:0]  c0;
        logic [1:0]  c1;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{64'h5,  8'd3, 2'd1, 2'b00, 2'b00},
        '{64'h4B, 8'd8, 2'd1, 2'b11, 2'b00},
        '{64'h6,  8'd3, 2'd2, 2'b11, 2'b00},
        '{64'h49, 8'd8, 2'd2, 2'b11, 2'b01},
        '{64'h7,  8'd3, 2'd2, 2'b11, 2'b01},
        '{64'h0,  8'd5, 2'd2, 2'b11, 2'b01},
        '{64'h5,  8'd3, 2'd1, 2'b11, 2'b01},
        '{64'h4A, 8'd8, 2'd1, 2'b10, 2'b01},
        '{64'h4,  8'd3, 2'd0, 2'b10, 2'b01},
        '{64'h25, 8'd7, 2'd0, 2'b10, 2'b01}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [63:0] v, input int n,
                        output logic [63:0] rd, output logic go_seen);
        rd = '0;
        @(negedge clk); cap = 1'b1;
        @(negedge clk); cap = 1'b0;
        for (int i = 0; i < n; i++) begin
            sh = 1'b1; tdi = v[i]; rd[i] = tdo;
            @(negedge clk);
        end
        sh = 1'b0; tdi = 1'b0; upd = 1'b1;
        @(negedge clk); upd = 1'b0;
        go_seen = go;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic        g;
        repeat (3) @(negedge clk);
        tlr = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 unit", 64'(unit), 64'd0);
        chk("R10 cpu bits", 64'({rstb, stall}), 64'd0);
        chk("R10 go", 64'(go), 64'd0);

        // table walk: R1 R2 R3 R5 R6 R12
        for (int k = 0; k < NV; k++) begin
            scan(VECS[k].v, int'(VECS[k].n), rd, g);
            chk("R2/R3 unit", 64'(unit), 64'(VECS[k].u));
            chk("R5/R12 cpu0", 64'({rstb[0], stall[0]}), 64'(VECS[k].c0));
            chk("R5/R12 cpu1", 64'({rstb[1], stall[1]}), 64'(VECS[k].c1));
        end

        // R6 readout of CPU 0 control register, then index 1
        scan(64'h5, 3, rd, g);
        scan(64'h1A, 6, rd, g);
        scan(64'h0, 5, rd, g);
        chk("R6 cpu0 idx0 readout", rd[4:0], 64'b00010);
        scan(64'h1B, 6, rd, g);
        scan(64'h0, 5, rd, g);
        chk("R4 cpu0 idx1 readout", rd[4:0], 64'd0);
        scan(64'h1A, 6, rd, g);

        // R7 error record, first error kept
        scan(64'h4, 3, rd, g);
        @(negedge clk); erep = 1'b1; eaddr = 32'hDEADBEEF;
        @(negedge clk); erep = 1'b1; eaddr = 32'h12345678;
        @(negedge clk); erep = 1'b0;
        scan(64'h1A, 6, rd, g);
        scan(64'h0, 37, rd, g);
        chk("R7 error record", rd[32:0], {31'd0, 32'hDEADBEEF, 1'b1});
        scan(64'h24, 7, rd, g);
        scan(64'h0, 37, rd, g);
        chk("R7 zero write keeps", rd[32:0], {31'd0, 32'hDEADBEEF, 1'b1});
        scan(64'h25, 7, rd, g);
        scan(64'h0, 37, rd, g);
        chk("R7 clear", rd[32:0], 64'd0);

        // R8 burst start
        scan((64'h3 << 48) | (64'h0000_1000 << 16) | 64'd16, 53, rd, g);
        chk("R8 go pulse", 64'(g), 64'd1);
        chk("R8 fields", {bop, baddr, blen, 2'b00, bunit}, {4'h3, 32'h1000, 16'd16, 4'd0});
        @(negedge clk);
        chk("R8 one cycle", 64'(go), 64'd0);
        scan(64'h6, 3, rd, g);
        scan((64'h7 << 48) | (64'hCAFE_0004 << 16) | 64'd2, 53, rd, g);
        chk("R8 read burst", {bop, baddr, blen, 2'b00, bunit, 3'b000, g},
            {4'h7, 32'hCAFE0004, 16'd2, 4'd2, 4'd1});

        // R9 busy blocks updates
        busy = 1'b1;
        scan(64'h4, 3, rd, g);
        chk("R9 pick ignored", 64'(unit), 64'd2);
        scan((64'h1 << 48) | 64'd4, 53, rd, g);
        chk("R9 no burst", 64'(g), 64'd0);
        busy = 1'b0;

        // R11 inactive instruction
        dsel = 1'b0;
        scan(64'h5, 3, rd, g);
        chk("R11 no decode", 64'(unit), 64'd2);
        dsel = 1'b1;
        scan(64'h5, 3, rd, g);
        chk("R11 decode again", 64'(unit), 64'd1);

        // R10 reset mid-run
        scan(64'h49, 8, rd, g);
        chk("R5 stall set", 64'({rstb[0], stall[0]}), 64'b01);
        @(negedge clk); tlr = 1'b1;
        @(negedge clk); tlr = 1'b0;
        @(negedge clk);
        chk("R10 unit after reset", 64'(unit), 64'd0);
        chk("R10 bits after reset", 64'({rstb, stall}), 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule